// File: doc/BRIEF.md
# IPv6 Five-Tuple Key Compactor

This block sits in front of a ternary match array. It shrinks the five header fields that identify a flow into one narrower search key, so that a rule entry and a packet key fit into fewer match bits. It takes two 128-bit IPv6 addresses, an 8-bit protocol number and two 16-bit transport ports, and produces a 235-bit key. The same block prepares both rule entries and packet lookups, so both sides are coded the same way.

Each address keeps its upper 64 bits as the routing prefix. The lower 64-bit interface identifier is turned back into the 48-bit hardware address it was built from: the two marker bytes in its middle are removed and the universal/local bit is flipped back. If the identifier does not carry the marker, the block does not compress it. It raises a per-address error flag and writes zeros into that address's MAC field. The protocol number becomes a 3-bit code and each port becomes a 4-bit service class.

Data moves through one register stage under a valid/ready handshake. A beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat is frozen and no new beat is taken.

Top module: `ipv6_tuple_compactor`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted beat, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat accepted at a clock edge shows up on `out_key`/`out_id_err`, with `out_valid` high, right after that edge. If no beat is accepted while the output is drained, `out_valid` drops to 0 after that edge.
- R3: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid`, `out_key` and `out_id_err` hold their values across the edge.
- R4: Each address's upper 64 bits are copied unchanged into its prefix field of the key.
- R5: When bits [39:24] of an address equal 16'hFFFE, its MAC field is {addr[63:56] ^ 8'h02, addr[55:40], addr[23:0]} and its error flag is 0.
- R6: When bits [39:24] of an address are not 16'hFFFE, its error flag is 1 (`out_id_err[1]` source, `out_id_err[0]` destination), its MAC field is all zeros, and its prefix is still copied.
- R7: Protocol numbers map to codes: 6→0, 17→1, 1→2, 2→3, 9→4, 88→4, 47→5, 4→6, and any other value→7.
- R8: Each port maps to a 4-bit class: 7→0, 13→1, 20..21→2, 23→3, 25→4, 53→5, 67..68→6, 70→7, 80→8, 110→9, 119→10, 137..139→11, 161..162→12, 194→13, 1024..65535→14.
- R9: Any port outside the ranges of R8 (for example 0, 22, 69, 1023) maps to class 15.
- R10: The key layout is: [234:171] source prefix, [170:123] source MAC, [122:59] destination prefix, [58:11] destination MAC, [10:8] protocol code, [7:4] source port class, [3:0] destination port class.
- R11: With `out_ready` held high, one beat is accepted on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat this cycle |
| in_src_addr | input | 128 | Source IPv6 address |
| in_dst_addr | input | 128 | Destination IPv6 address |
| in_proto | input | 8 | IP protocol number |
| in_src_port | input | 16 | Source transport port |
| in_dst_port | input | 16 | Destination transport port |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_key | output | 235 | Compacted search key |
| out_id_err | output | 2 | Identifier lacks the marker: bit 1 source, bit 0 destination |

## Verification
Every compressed field comes out exactly one clock edge after the beat is accepted, so a result is due at the negative edge that follows the accepting rising edge. It stays due for as long as `out_ready` is low. The bench decides in the half-cycle before each rising edge whether a beat will transfer, and queues the expected key only for beats that will. The monitor compares at the same point in the cycle, and only when `out_valid` and `out_ready` are both high, so each queued item is matched with the beat that leaves on the next edge. Stalled beats are also checked for stability one cycle later, and a burst is timed to confirm one acceptance per edge.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  localparam int ADDR_W  = 128;
  localparam int PFX_W   = 64;
  localparam int MAC_W   = 48;
  localparam int PROTO_W = 8;
  localparam int PORT_W  = 16;
  localparam int PCODE_W = 3;
  localparam int PCLS_W  = 4;

  localparam int IID_W   = ADDR_W - PFX_W;
  localparam int MARK_W  = IID_W - MAC_W;
  localparam int HALF_W  = MAC_W / 2;
  localparam int KEY_W   = 2 * (PFX_W + MAC_W) + PCODE_W + 2 * PCLS_W;

  // key field positions, low to high
  localparam int DCLS_LSB  = 0;
  localparam int SCLS_LSB  = DCLS_LSB + PCLS_W;
  localparam int PCODE_LSB = SCLS_LSB + PCLS_W;
  localparam int DMAC_LSB  = PCODE_LSB + PCODE_W;
  localparam int DPFX_LSB  = DMAC_LSB + MAC_W;
  localparam int SMAC_LSB  = DPFX_LSB + PFX_W;
  localparam int SPFX_LSB  = SMAC_LSB + MAC_W;

  localparam int N_PROTO_ENT = 8;
  localparam int N_PORT_CLS  = 15;

  typedef logic [PCODE_W-1:0] pcode_t;
  typedef logic [PCLS_W-1:0]  pcls_t;

  // protocol table: number and the code it maps to
  function automatic int proto_num(input int idx);
    case (idx)
      0: return 6;
      1: return 17;
      2: return 1;
      3: return 2;
      4: return 9;
      5: return 88;
      6: return 47;
      default: return 4;
    endcase
  endfunction

  function automatic int proto_code(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 4;
      5: return 4;
      6: return 5;
      default: return 6;
    endcase
  endfunction

  // service class bounds; class index equals the emitted code
  function automatic int cls_lo(input int idx);
    case (idx)
      0: return 7;
      1: return 13;
      2: return 20;
      3: return 23;
      4: return 25;
      5: return 53;
      6: return 67;
      7: return 70;
      8: return 80;
      9: return 110;
      10: return 119;
      11: return 137;
      12: return 161;
      13: return 194;
      default: return 1024;
    endcase
  endfunction

  function automatic int cls_hi(input int idx);
    case (idx)
      0: return 7;
      1: return 13;
      2: return 21;
      3: return 23;
      4: return 25;
      5: return 53;
      6: return 68;
      7: return 70;
      8: return 80;
      9: return 110;
      10: return 119;
      11: return 139;
      12: return 162;
      13: return 194;
      default: return 65535;
    endcase
  endfunction

endpackage

// File: rtl/ftc_iid_unpack.sv
module ftc_iid_unpack #(
  parameter int ADDR_W = ftc_pkg::ADDR_W,
  parameter int PFX_W  = ftc_pkg::PFX_W,
  parameter int MAC_W  = ftc_pkg::MAC_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PFX_W-1:0]  prefix_o,
  output logic [MAC_W-1:0]  mac_o,
  output logic              err_o
);
  localparam int IID_W  = ADDR_W - PFX_W;
  localparam int MARK_W = IID_W - MAC_W;
  localparam int HALF_W = MAC_W / 2;
  localparam logic [MARK_W-1:0] MARKER  = MARK_W'('hFFFE);
  localparam logic [HALF_W-1:0] UL_FLIP = HALF_W'(1) << (HALF_W - 7);

  logic [IID_W-1:0]  iid;
  logic [MARK_W-1:0] mark;
  logic [HALF_W-1:0] oui_part;
  logic [HALF_W-1:0] nic_part;

  assign prefix_o = addr_i[ADDR_W-1 -: PFX_W];
  assign iid      = addr_i[IID_W-1:0];
  assign mark     = iid[HALF_W +: MARK_W];
  assign oui_part = iid[IID_W-1 -: HALF_W] ^ UL_FLIP;
  assign nic_part = iid[HALF_W-1:0];

  always_comb begin
    err_o = (mark != MARKER);
    mac_o = err_o ? '0 : {oui_part, nic_part};
  end
endmodule

// File: rtl/ftc_proto_map.sv
module ftc_proto_map #(
  parameter int PROTO_W = ftc_pkg::PROTO_W,
  parameter int PCODE_W = ftc_pkg::PCODE_W,
  parameter int N_ENT   = ftc_pkg::N_PROTO_ENT
) (
  input  logic [PROTO_W-1:0] proto_i,
  output logic [PCODE_W-1:0] code_o
);
  localparam logic [PCODE_W-1:0] WILD = '1;

  logic [N_ENT-1:0] hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign hit[e] = (proto_i == PROTO_W'(ftc_pkg::proto_num(e)));
  end

  always_comb begin
    code_o = WILD;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (hit[e]) code_o = PCODE_W'(ftc_pkg::proto_code(e));
    end
  end
endmodule

// File: rtl/ftc_port_class.sv
module ftc_port_class #(
  parameter int PORT_W = ftc_pkg::PORT_W,
  parameter int PCLS_W = ftc_pkg::PCLS_W,
  parameter int N_CLS  = ftc_pkg::N_PORT_CLS
) (
  input  logic [PORT_W-1:0] port_i,
  output logic [PCLS_W-1:0] cls_o
);
  localparam logic [PCLS_W-1:0] WILD = '1;

  logic [N_CLS-1:0] hit;
  int               port_v;

  assign port_v = int'(port_i);

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    assign hit[c] = (port_v >= ftc_pkg::cls_lo(c)) && (port_v <= ftc_pkg::cls_hi(c));
  end

  // lowest-numbered hit wins; ranges are disjoint so at most one fires
  always_comb begin
    cls_o = WILD;
    for (int c = N_CLS - 1; c >= 0; c--) begin
      if (hit[c]) cls_o = PCLS_W'(c);
    end
  end
endmodule

// File: rtl/ipv6_tuple_compactor.sv
module ipv6_tuple_compactor #(
  parameter int ADDR_W  = ftc_pkg::ADDR_W,
  parameter int PFX_W   = ftc_pkg::PFX_W,
  parameter int MAC_W   = ftc_pkg::MAC_W,
  parameter int PROTO_W = ftc_pkg::PROTO_W,
  parameter int PORT_W  = ftc_pkg::PORT_W,
  parameter int PCODE_W = ftc_pkg::PCODE_W,
  parameter int PCLS_W  = ftc_pkg::PCLS_W,
  parameter int KEY_W   = 2 * (PFX_W + MAC_W) + PCODE_W + 2 * PCLS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_src_addr,
  input  logic [ADDR_W-1:0]  in_dst_addr,
  input  logic [PROTO_W-1:0] in_proto,
  input  logic [PORT_W-1:0]  in_src_port,
  input  logic [PORT_W-1:0]  in_dst_port,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [KEY_W-1:0]   out_key,
  output logic [1:0]         out_id_err
);
  localparam int N_SIDE = 2;  // index 0 source, 1 destination

  logic [ADDR_W-1:0]  addr_a [N_SIDE];
  logic [PORT_W-1:0]  port_a [N_SIDE];
  logic [PFX_W-1:0]   pfx_a  [N_SIDE];
  logic [MAC_W-1:0]   mac_a  [N_SIDE];
  logic [PCLS_W-1:0]  cls_a  [N_SIDE];
  logic [N_SIDE-1:0]  err_a;
  logic [PCODE_W-1:0] pcode;
  logic [KEY_W-1:0]   key_next;
  logic               take;

  assign addr_a[0] = in_src_addr;
  assign addr_a[1] = in_dst_addr;
  assign port_a[0] = in_src_port;
  assign port_a[1] = in_dst_port;

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    ftc_iid_unpack #(
      .ADDR_W(ADDR_W), .PFX_W(PFX_W), .MAC_W(MAC_W)
    ) u_unpack (
      .addr_i  (addr_a[s]),
      .prefix_o(pfx_a[s]),
      .mac_o   (mac_a[s]),
      .err_o   (err_a[s])
    );

    ftc_port_class #(
      .PORT_W(PORT_W), .PCLS_W(PCLS_W), .N_CLS(ftc_pkg::N_PORT_CLS)
    ) u_pcls (
      .port_i(port_a[s]),
      .cls_o (cls_a[s])
    );
  end

  ftc_proto_map #(
    .PROTO_W(PROTO_W), .PCODE_W(PCODE_W), .N_ENT(ftc_pkg::N_PROTO_ENT)
  ) u_proto (
    .proto_i(in_proto),
    .code_o (pcode)
  );

  assign key_next = {pfx_a[0], mac_a[0], pfx_a[1], mac_a[1], pcode, cls_a[0], cls_a[1]};

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_key    <= '0;
      out_id_err <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_key    <= key_next;
        out_id_err <= {err_a[0], err_a[1]};
      end
    end
  end
endmodule

// File: rtl/ipv6_tuple_compactor_chk.sv
module ipv6_tuple_compactor_chk
  import ftc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [ADDR_W-1:0]   in_src_addr,
  input logic [ADDR_W-1:0]   in_dst_addr,
  input logic [PROTO_W-1:0]  in_proto,
  input logic [PORT_W-1:0]   in_src_port,
  input logic [PORT_W-1:0]   in_dst_port,
  input logic                out_valid,
  input logic                out_ready,
  input logic [KEY_W-1:0]    out_key,
  input logic [1:0]          out_id_err
);
  localparam logic [MARK_W-1:0] MK = MARK_W'('hFFFE);

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid && in_ready);

  // R2
  a_r2_accept_appears: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  a_r2_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !in_valid |=> !out_valid);

  // R3
  a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_id_err));
  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R4
  a_r4_src_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_key[SPFX_LSB +: PFX_W] == $past(in_src_addr[ADDR_W-1 -: PFX_W]));
  a_r4_dst_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_key[DPFX_LSB +: PFX_W] == $past(in_dst_addr[ADDR_W-1 -: PFX_W]));

  // R5
  a_r5_src_marker_ok: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_src_addr[HALF_W +: MARK_W] == MK |=> !out_id_err[1]);
  a_r5_src_mac_low: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_src_addr[HALF_W +: MARK_W] == MK |=>
    out_key[SMAC_LSB +: HALF_W] == $past(in_src_addr[HALF_W-1:0]));

  // R6
  a_r6_src_marker_bad: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_src_addr[HALF_W +: MARK_W] != MK |=> out_id_err[1] && out_key[SMAC_LSB +: MAC_W] == '0);
  a_r6_dst_marker_bad: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_dst_addr[HALF_W +: MARK_W] != MK |=> out_id_err[0] && out_key[DMAC_LSB +: MAC_W] == '0);

  // R7
  a_r7_tcp_code: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_proto == PROTO_W'(6) |=> out_key[PCODE_LSB +: PCODE_W] == '0);

  // R8
  a_r8_web_class: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_src_port == PORT_W'(80) |=> out_key[SCLS_LSB +: PCLS_W] == PCLS_W'(8));

  // R9
  a_r9_zero_port_wild: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_dst_port == '0 |=> out_key[DCLS_LSB +: PCLS_W] == '1);
endmodule

bind ipv6_tuple_compactor ipv6_tuple_compactor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_src_addr(in_src_addr),
  .in_dst_addr(in_dst_addr),
  .in_proto   (in_proto),
  .in_src_port(in_src_port),
  .in_dst_port(in_dst_port),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_key    (out_key),
  .out_id_err (out_id_err)
);

// File: tb/ipv6_tuple_compactor_bench.sv
`timescale 1ns/100ps
module ipv6_tuple_compactor_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_src_addr = '0;
  logic [127:0] in_dst_addr = '0;
  logic [7:0]   in_proto = '0;
  logic [15:0]  in_src_port = '0;
  logic [15:0]  in_dst_port = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [234:0] out_key;
  logic [1:0]   out_id_err;

  always #2 clk = ~clk;

  ipv6_tuple_compactor u_ipv6_tuple_compactor (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src_addr(in_src_addr), .in_dst_addr(in_dst_addr),
    .in_proto(in_proto), .in_src_port(in_src_port), .in_dst_port(in_dst_port),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_key(out_key), .out_id_err(out_id_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  logic [234:0] exp_key_q [$];
  logic [1:0]   exp_err_q [$];

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- reference model written from the requirements
  function automatic logic [3:0] ref_cls(input int p);
    if (p == 7)                    return 4'd0;
    else if (p == 13)              return 4'd1;
    else if (p == 20 || p == 21)   return 4'd2;
    else if (p == 23)              return 4'd3;
    else if (p == 25)              return 4'd4;
    else if (p == 53)              return 4'd5;
    else if (p == 67 || p == 68)   return 4'd6;
    else if (p == 70)              return 4'd7;
    else if (p == 80)              return 4'd8;
    else if (p == 110)             return 4'd9;
    else if (p == 119)             return 4'd10;
    else if (p >= 137 && p <= 139) return 4'd11;
    else if (p == 161 || p == 162) return 4'd12;
    else if (p == 194)             return 4'd13;
    else if (p >= 1024)            return 4'd14;
    return 4'd15;
  endfunction

  function automatic logic [2:0] ref_pcode(input int n);
    case (n)
      6: return 3'd0;
      17: return 3'd1;
      1: return 3'd2;
      2: return 3'd3;
      9, 88: return 3'd4;
      47: return 3'd5;
      4: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [48:0] ref_mac(input logic [127:0] a); // {err, mac}
    if (a[39:24] != 16'hFFFE) return {1'b1, 48'h0};
    return {1'b0, a[63:56] ^ 8'h02, a[55:40], a[23:0]};
  endfunction

  function automatic logic [127:0] mk_addr(input logic [63:0] pfx, input logic [47:0] mac, input bit good);
    if (good) return {pfx, mac[47:40] ^ 8'h02, mac[39:24], 16'hFFFE, mac[23:0]};
    return {pfx, mac, 16'hFFFF};
  endfunction

  // ---------------- driver
  task automatic send(input logic [127:0] s, input logic [127:0] d, input logic [7:0] pr,
                      input logic [15:0] sp, input logic [15:0] dp);
    logic [48:0] sm;
    logic [48:0] dm;
    in_valid = 1'b1; in_src_addr = s; in_dst_addr = d;
    in_proto = pr; in_src_port = sp; in_dst_port = dp;
    forever begin
      #1;
      if (in_ready) begin
        sm = ref_mac(s);
        dm = ref_mac(d);
        exp_key_q.push_back({s[127:64], sm[47:0], d[127:64], dm[47:0],
                             ref_pcode(int'(pr)), ref_cls(int'(sp)), ref_cls(int'(dp))});
        exp_err_q.push_back({sm[48], dm[48]});
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // ---------------- downstream ready pattern
  always @(negedge clk) begin
    out_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  // ---------------- monitor
  logic [234:0] held_key;
  logic [1:0]   held_err;
  bit           held = 1'b0;

  always @(negedge clk) begin
    logic [234:0] ek;
    logic [1:0]   ee;
    #1.5;
    if (rst_n) begin
      if (held) begin
        check("R3 stalled key stable", 256'(out_key), 256'(held_key));
        check("R3 stalled flags stable", 256'(out_id_err), 256'(held_err));
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        check("R3 in_ready low while stalled", 256'(in_ready), 256'(0));
        held_key = out_key; held_err = out_id_err; held = 1'b1;
      end
      if (out_valid && out_ready) begin
        if (exp_key_q.size() == 0) begin
          check("R2 unexpected output beat", 256'(1), 256'(0));
        end else begin
          ek = exp_key_q.pop_front();
          ee = exp_err_q.pop_front();
          check("R4 source prefix", 256'(out_key[234:171]), 256'(ek[234:171]));
          check("R4 destination prefix", 256'(out_key[122:59]), 256'(ek[122:59]));
          check(ee[1] ? "R6 source MAC zeroed" : "R5 source MAC", 256'(out_key[170:123]), 256'(ek[170:123]));
          check(ee[0] ? "R6 destination MAC zeroed" : "R5 destination MAC", 256'(out_key[58:11]), 256'(ek[58:11]));
          check("R5 R6 identifier flags", 256'(out_id_err), 256'(ee));
          check("R7 protocol code", 256'(out_key[10:8]), 256'(ek[10:8]));
          check(ek[7:4] == 4'd15 ? "R9 source class" : "R8 source class", 256'(out_key[7:4]), 256'(ek[7:4]));
          check(ek[3:0] == 4'd15 ? "R9 destination class" : "R8 destination class", 256'(out_key[3:0]), 256'(ek[3:0]));
          check("R10 full key layout", 256'(out_key), 256'(ek));
        end
      end
    end
  end

  // ---------------- watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus
  int ports [26] = '{7, 13, 20, 21, 19, 22, 23, 25, 53, 67, 68, 69, 70, 80,
                     110, 119, 137, 139, 140, 161, 162, 194, 1023, 1024, 65535, 0};
  int protos [10] = '{6, 17, 1, 2, 9, 88, 47, 4, 0, 255};

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    #1.5;
    check("R1 out_valid low in reset", 256'(out_valid), 256'(0));
    check("R1 in_ready high in reset", 256'(in_ready), 256'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1.5;
    check("R1 out_valid low after release", 256'(out_valid), 256'(0));
    check("R1 in_ready high after release", 256'(in_ready), 256'(1));
    @(negedge clk);

    // R2 single-beat latency and drain
    send(mk_addr(64'h2001_0db8_0000_0001, 48'h00_1b_21_aa_bb_cc, 1'b1),
         mk_addr(64'h2001_0db8_0000_0002, 48'h02_00_5e_10_20_30, 1'b1), 8'd6, 16'd80, 16'd1024);
    in_valid = 1'b0;
    #1.5;
    check("R2 out_valid one edge after accept", 256'(out_valid), 256'(1));
    @(negedge clk);
    #1.5;
    check("R2 out_valid drops after drain", 256'(out_valid), 256'(0));
    @(negedge clk);

    // R11 back-to-back burst over all boundary ports
    c0 = cyc;
    for (int i = 0; i < 26; i++) begin
      send(mk_addr(64'h3ffe_0000_0000_0000 + 64'(i), 48'h0a_00_00_00_00_00 + 48'(i * 257), (i % 5) != 3),
           mk_addr(64'hfe80_0000_0000_0000 + 64'(i), 48'hfc_ff_ee_00_00_00 + 48'(i), (i % 7) != 2),
           8'(protos[i % 10]), 16'(ports[i]), 16'(ports[25 - i]));
    end
    check("R11 one acceptance per edge", 256'(cyc - c0), 256'(26));
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R3 stalls with back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 20; i++) begin
      send(mk_addr(64'hdead_beef_0000_0000 ^ 64'(i), 48'h5c_26_0a_00_00_00 + 48'(i), (i % 4) != 1),
           mk_addr(64'h2400_cb00_0000_0000 + 64'(i << 8), 48'h00_00_00_ff_ff_00 + 48'(i), (i % 3) != 0),
           8'(protos[(i * 3) % 10]), 16'(ports[(i * 5) % 26]), 16'(ports[(i * 7) % 26]));
    end
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 every accepted beat delivered", 256'(exp_key_q.size()), 256'(0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule